// File: doc/BRIEF.md
# Watchdog Counter with Stop and Wait Mode Handling

This block is a watchdog timer for a small processor that can enter two low-power modes. In normal operation the counter advances by one each clock. Software must clear it with a service strobe before it reaches a terminal count. If software fails to do so, the block raises a one-cycle reset request and the counter wraps to zero.

A wait entry changes nothing in the watchdog, so software that waits too long is still caught. A stop entry clears the count and gates the watchdog clock. While the processor is stopped, the count stays at zero.

Two events can end a stop, and each one starts an internal oscillator stabilization delay. During that delay the watchdog counts from zero. An interrupt wake lets the count run on past the end of the delay. A reset wake clears the count again when the delay ends. A static option bit converts every stop request into a wait, which keeps the watchdog running throughout.

Top module: `wdog_lp_top`

## Requirements
- R1: While the asynchronous active-low reset is held, the count is 0, the reset request is 0 and the oscillator-stable output is 1 (running mode).
- R2: In running mode, and also during the stabilization delay, the count rises by exactly one on each clock edge when there is no service strobe, no stop entry and no terminal count.
- R3: When the count equals TERMINAL and it is enabled, the next edge sets the count to 0 and raises the reset request for exactly one cycle.
- R4: A service strobe sets the count to 0 on the next edge. The strobe beats both the increment and the terminal count, so no reset request is raised.
- R5: A stop request (stop_req_i=1 with stop_to_wait_i=0) in running mode clears the count to 0 on the next edge, even when the count is at TERMINAL, and raises no reset request. While stopped the count stays 0 and service strobes have no visible effect.
- R6: An interrupt wake (wake_irq_i=1 in stop mode) leaves the count at 0 on the wake edge. The count then rises by one per edge through the delay and keeps counting when the delay ends.
- R7: A reset wake (wake_rst_i=1 in stop mode, taking priority over an interrupt wake in the same cycle) counts like R6 during the delay. On the edge that ends the delay, the count is set to 0.
- R8: The oscillator-stable output is 0 from the stop-entry edge until exactly STAB_CYCLES edges after the wake edge, and then it returns to 1.
- R9: A wait request has no effect: counting, time-out and the reset request proceed exactly as without it.
- R10: With stop_to_wait_i=1, a stop request behaves as a wait: the count is neither cleared nor held, and the oscillator-stable output stays 1.
- R11: Wake events outside stop mode are ignored. A stop request during the stabilization delay is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| kick_i | input | 1 | Watchdog service strobe |
| stop_req_i | input | 1 | Stop-entry pulse |
| wait_req_i | input | 1 | Wait-entry pulse |
| wake_irq_i | input | 1 | External-interrupt wake event |
| wake_rst_i | input | 1 | Reset wake event |
| stop_to_wait_i | input | 1 | Static option: treat stop as wait |
| count_o | output | CNT_W | Current watchdog count |
| wdt_reset_o | output | 1 | One-cycle watchdog reset request |
| osc_stable_o | output | 1 | High when the stabilization delay is not pending |

## Verification
The checker watches several relations on every cycle. The request lasts one cycle and coincides with a zero count. A count below terminal advances by one while enabled, and a service strobe clears it. The count stays at zero while stopped, and the option bit keeps the block out of stop. At the end of a reset-cause delay the count is zero, and a wake always drops oscillator-stable. Some properties only the bench scenarios can show: the full time-out period, the exact length of the stabilization delay, the different restart points for the two wake causes, and the priority of stop entry over a pending terminal count. The bench sweeps these across every count value of a small configuration.

// File: rtl/wdog_lp_pkg.sv
package wdog_lp_pkg;

    typedef enum logic [1:0] {
        MODE_RUN      = 2'd0,
        MODE_STOP     = 2'd1,
        MODE_STAB_IRQ = 2'd2,
        MODE_STAB_RST = 2'd3
    } lp_mode_e;

endpackage

// File: rtl/wdog_stab_delay.sv
module wdog_stab_delay #(
    parameter int STAB_CYCLES = 4064
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam int DW = $clog2(STAB_CYCLES + 1);
    localparam logic [DW-1:0] LAST = DW'(STAB_CYCLES - 1);

    typedef struct packed {
        logic [DW-1:0] dly;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.dly = '0;
        end else if (run_i && st_q.dly != LAST) begin
            st_d.dly = st_q.dly + DW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = run_i && (st_q.dly == LAST);

endmodule

// File: rtl/wdog_lp_ctrl.sv
module wdog_lp_ctrl
    import wdog_lp_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     stop_req_i,
    input  logic     wait_req_i,
    input  logic     wake_irq_i,
    input  logic     wake_rst_i,
    input  logic     stop_to_wait_i,
    input  logic     dly_done_i,
    output lp_mode_e mode_o,
    output logic     cnt_clear_o,
    output logic     cnt_enable_o,
    output logic     dly_start_o,
    output logic     dly_run_o
);
    typedef struct packed {
        lp_mode_e mode;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic enter_lp;
    logic stop_kind;
    logic go_stop;
    logic any_wake;

    always_comb begin
        enter_lp  = stop_req_i || wait_req_i;
        stop_kind = stop_req_i && !stop_to_wait_i;
        go_stop   = enter_lp && stop_kind;
        any_wake  = wake_irq_i || wake_rst_i;

        st_d         = st_q;
        cnt_clear_o  = 1'b0;
        dly_start_o  = 1'b0;

        unique case (st_q.mode)
            MODE_RUN: begin
                if (go_stop) begin
                    st_d.mode   = MODE_STOP;
                    cnt_clear_o = 1'b1;
                end
            end
            MODE_STOP: begin
                if (any_wake) begin
                    dly_start_o = 1'b1;
                    st_d.mode   = wake_rst_i ? MODE_STAB_RST : MODE_STAB_IRQ;
                end
            end
            MODE_STAB_IRQ: begin
                if (dly_done_i) begin
                    st_d.mode = MODE_RUN;
                end
            end
            MODE_STAB_RST: begin
                if (dly_done_i) begin
                    st_d.mode   = MODE_RUN;
                    cnt_clear_o = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o       = st_q.mode;
    assign cnt_enable_o = (st_q.mode != MODE_STOP);
    assign dly_run_o    = (st_q.mode == MODE_STAB_IRQ) || (st_q.mode == MODE_STAB_RST);

endmodule

// File: rtl/wdog_cop_count.sv
module wdog_cop_count #(
    parameter int CNT_W    = 16,
    parameter int TERMINAL = 50000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             kick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             bark_o
);
    localparam logic [CNT_W-1:0] TERM_C = CNT_W'(TERMINAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bark;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bark = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (enable_i) begin
            if (kick_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == TERM_C) begin
                st_d.cnt  = '0;
                st_d.bark = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign bark_o  = st_q.bark;

endmodule

// File: rtl/wdog_lp_top.sv
module wdog_lp_top
    import wdog_lp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TERMINAL    = 50000,
    parameter int STAB_CYCLES = 4064
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             kick_i,
    input  logic             stop_req_i,
    input  logic             wait_req_i,
    input  logic             wake_irq_i,
    input  logic             wake_rst_i,
    input  logic             stop_to_wait_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wdt_reset_o,
    output logic             osc_stable_o
);
    lp_mode_e mode_q;
    logic     cnt_clear;
    logic     cnt_enable;
    logic     dly_start;
    logic     dly_run;
    logic     dly_done;

    wdog_lp_ctrl u_ctrl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .stop_req_i    (stop_req_i),
        .wait_req_i    (wait_req_i),
        .wake_irq_i    (wake_irq_i),
        .wake_rst_i    (wake_rst_i),
        .stop_to_wait_i(stop_to_wait_i),
        .dly_done_i    (dly_done),
        .mode_o        (mode_q),
        .cnt_clear_o   (cnt_clear),
        .cnt_enable_o  (cnt_enable),
        .dly_start_o   (dly_start),
        .dly_run_o     (dly_run)
    );

    wdog_stab_delay #(
        .STAB_CYCLES(STAB_CYCLES)
    ) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(dly_start),
        .run_i  (dly_run),
        .done_o (dly_done)
    );

    wdog_cop_count #(
        .CNT_W   (CNT_W),
        .TERMINAL(TERMINAL)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (cnt_clear),
        .enable_i(cnt_enable),
        .kick_i  (kick_i),
        .count_o (count_o),
        .bark_o  (wdt_reset_o)
    );

    assign osc_stable_o = (mode_q == MODE_RUN);

endmodule

// File: rtl/wdog_lp_checker.sv
module wdog_lp_checker
    import wdog_lp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TERMINAL = 50000
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             kick_i,
    input logic             stop_req_i,
    input logic             wait_req_i,
    input logic             wake_irq_i,
    input logic             wake_rst_i,
    input logic             stop_to_wait_i,
    input logic [CNT_W-1:0] count_o,
    input logic             wdt_reset_o,
    input logic             osc_stable_o,
    input lp_mode_e         mode_q
);
    localparam logic [CNT_W-1:0] TERM_C = CNT_W'(TERMINAL);

    logic counting;
    logic stop_now;
    assign counting = (mode_q != MODE_STOP);
    assign stop_now = (mode_q == MODE_RUN) && stop_req_i && !stop_to_wait_i;

    p_pulse_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_reset_o |=> !wdt_reset_o);

    p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_reset_o |-> (count_o == '0));

    p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (counting && !kick_i && !stop_now && !wake_rst_i && count_o != TERM_C
         && mode_q != MODE_STAB_RST)
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    p_kick_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (counting && kick_i) |=> (count_o == '0 && !wdt_reset_o));

    p_stop_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_STOP) |-> (count_o == '0 && !wdt_reset_o));

    p_rst_wake_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_RUN && $past(mode_q) == MODE_STAB_RST) |-> (count_o == '0));

    p_wake_unstable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_STOP && (wake_irq_i || wake_rst_i)) |=> !osc_stable_o);

    p_wait_counts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_RUN && wait_req_i && !stop_req_i && !kick_i && count_o != TERM_C)
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    p_convert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_RUN && stop_to_wait_i) |=> osc_stable_o);

    p_wake_in_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_RUN && !stop_req_i) |=> osc_stable_o);

endmodule

bind wdog_lp_top wdog_lp_checker #(
    .CNT_W   (CNT_W),
    .TERMINAL(TERMINAL)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .kick_i        (kick_i),
    .stop_req_i    (stop_req_i),
    .wait_req_i    (wait_req_i),
    .wake_irq_i    (wake_irq_i),
    .wake_rst_i    (wake_rst_i),
    .stop_to_wait_i(stop_to_wait_i),
    .count_o       (count_o),
    .wdt_reset_o   (wdt_reset_o),
    .osc_stable_o  (osc_stable_o),
    .mode_q        (mode_q)
);

// File: tb/wdog_lp_top_test.sv
`timescale 1ns/1ps
module wdog_lp_top_test;
    localparam int CW = 4;
    localparam int T  = 11;
    localparam int S  = 6;
    localparam int P  = T + 1;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          kick = 1'b0, stop_req = 1'b0, wait_req = 1'b0;
    logic          wake_irq = 1'b0, wake_rst = 1'b0, s2w = 1'b0;
    logic [CW-1:0] count;
    logic          bark, osc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wdog_lp_top #(.CNT_W(CW), .TERMINAL(T), .STAB_CYCLES(S)) uut (
        .clk_i(clk), .rst_ni(rst_ni), .kick_i(kick), .stop_req_i(stop_req),
        .wait_req_i(wait_req), .wake_irq_i(wake_irq), .wake_rst_i(wake_rst),
        .stop_to_wait_i(s2w), .count_o(count), .wdt_reset_o(bark), .osc_stable_o(osc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic zero_count();
        kick = 1'b1;
        step();
        kick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1 reset state
        #22;
        chk("R1 count", int'(count), 0);
        chk("R1 request", int'(bark), 0);
        chk("R1 osc", int'(osc), 1);
        rst_ni = 1'b1;

        // R2 / R3 free run over three periods
        for (int n = 1; n <= 3 * P; n++) begin
            step();
            chk("R2 count", int'(count), n % P);
            chk("R3 request", int'(bark), (n % P == 0) ? 1 : 0);
        end

        // R4 service at every count value, including terminal
        for (int v = 0; v <= T; v++) begin
            zero_count();
            repeat (v) step();
            chk("R4 before", int'(count), v);
            kick = 1'b1;
            step();
            kick = 1'b0;
            chk("R4 count", int'(count), 0);
            chk("R4 request", int'(bark), 0);
        end

        // R5..R8, R11 stop at every count, wake by both causes
        for (int v = 0; v <= T; v++) begin
            zero_count();
            repeat (v) step();
            stop_req = 1'b1;
            step();
            stop_req = 1'b0;
            chk("R5 count", int'(count), 0);
            chk("R5 request", int'(bark), 0);
            chk("R8 osc low", int'(osc), 0);
            kick = 1'b1;
            repeat (3) begin
                step();
                chk("R5 held", int'(count), 0);
            end
            kick = 1'b0;
            if (v % 2 == 1) wake_rst = 1'b1;
            else            wake_irq = 1'b1;
            step();
            wake_rst = 1'b0;
            wake_irq = 1'b0;
            chk("R6 wake edge", int'(count), 0);
            chk("R8 wake osc", int'(osc), 0);
            for (int k = 1; k <= S; k++) begin
                stop_req = (v == 0 && k == 3);
                step();
                stop_req = 1'b0;
                if (k < S) begin
                    chk((v % 2 == 1) ? "R7 delay count" : "R6 delay count", int'(count), k);
                    chk("R8 osc pending", int'(osc), 0);
                end else begin
                    chk((v % 2 == 1) ? "R7 end count" : "R6 end count", int'(count),
                        (v % 2 == 1) ? 0 : S);
                    chk("R8 osc end", int'(osc), 1);
                end
            end
            step();
            chk((v % 2 == 1) ? "R7 after" : "R6 after", int'(count), (v % 2 == 1) ? 1 : S + 1);
        end

        // R10 stop converted to wait, R11 wake in run ignored
        s2w = 1'b1;
        zero_count();
        for (int n = 1; n <= P; n++) begin
            stop_req = (n == 4);
            wake_irq = (n == 7);
            step();
            stop_req = 1'b0;
            wake_irq = 1'b0;
            chk("R10 count", int'(count), n % P);
            chk("R10 request", int'(bark), (n == P) ? 1 : 0);
            chk("R10 osc", int'(osc), 1);
        end
        s2w = 1'b0;

        // R9 wait has no effect, R11 reset wake in run ignored
        zero_count();
        for (int n = 1; n <= 2 * P; n++) begin
            wait_req = 1'b1;
            wake_rst = (n == 5);
            step();
            wake_rst = 1'b0;
            chk("R9 count", int'(count), n % P);
            chk("R9 request", int'(bark), (n % P == 0) ? 1 : 0);
            chk("R11 osc", int'(osc), 1);
        end
        wait_req = 1'b0;

        finish_run();
    end

endmodule